// File: doc/BRIEF.md
# Quad I/O flash read sequencer

This block turns a read request into one Quad I/O Fast Read transaction on a serial NOR flash. A request is a 24-bit byte address and a burst length in 32-bit words, offered with a valid/ready handshake. The block lowers chip select and shifts out the fixed 1-4-4 phase sequence: the read opcode on lane 0, then the address on all four lanes, then a mode byte whose upper nibble is forced to 0xF so the device never enters continuous-read mode, then four turnaround cycles. After that it samples read data on the four lanes. The words come back on a result port, each marked by a one-cycle strobe.

The serial clock is the system clock divided by the even parameter `CLK_DIV`. It idles low (SPI mode 0). Outgoing lane values change when the serial clock falls, and incoming nibbles are captured when it rises. Chip select has a programmable setup time before the first serial clock edge and a hold time after the last one. A minimum high time is then enforced before the next request is taken. A whole burst is served from a single command inside one chip-select low period.

The four flash lanes appear as separate out, enable and in vectors, so that the pad tristate buffer can sit outside the block.

Top module: `qspi_quad_reader`

## Requirements
- R1: After reset, `flash_cs_n` is 1, `flash_sck` is 0, `flash_oe` is 4'b0000, `rd_valid` is 0 and `req_ready` is 1.
- R2: The first 8 serial clock cycles of a transaction carry opcode 0xEB on `flash_dout[0]`, MSB first. During these cycles `flash_oe` is exactly 4'b0001.
- R3: Serial cycles 8 to 13 carry the 24-bit request address on `flash_dout[3:0]`, most significant nibble first, with `flash_oe` = 4'b1111. A burst that runs past address 0xFFFFFF continues from address 0 inside the same transaction, without a second command.
- R4: Serial cycles 14 and 15 carry the mode byte with `flash_oe` = 4'b1111. The upper nibble of the mode byte is always 0xF, and the lower nibble is the `MODE_LOW` parameter.
- R5: Serial cycles 16 to 19 are dummy cycles. From the first dummy cycle until chip select rises, `flash_oe` is 4'b0000. A request of N words uses exactly 20 + 8N serial clock cycles.
- R6: Data nibbles are captured from `flash_din` on rising serial clock edges, high nibble of each byte first. The first byte read lands in `rd_data[7:0]`, the second in `[15:8]`, and so on (little-endian). `rd_valid` pulses for one cycle per word, in the cycle in which the serial clock goes high for that word's eighth nibble.
- R7: A request with `req_len` = L returns exactly L+1 words, all within one chip-select low period.
- R8: The first rising edge of `flash_sck` comes `CS_SETUP + CLK_DIV/2` system cycles after `flash_cs_n` falls.
- R9: `flash_cs_n` rises `CS_HOLD` system cycles after the last falling edge of `flash_sck`. While `flash_cs_n` is high, `flash_sck` is 0 and `flash_oe` is 4'b0000.
- R10: `req_ready` is 0 from the accepting edge until at least `CS_GAP` cycles after `flash_cs_n` rises. Chip select only falls on the edge after a handshake.
- R11: Consecutive rising edges of `flash_sck` within a transaction are exactly `CLK_DIV` system cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 24 | Flash byte address of the first word |
| req_len | input | LEN_W | Burst length minus one, in 32-bit words |
| rd_valid | output | 1 | One-cycle strobe for a completed word |
| rd_data | output | 32 | Assembled little-endian read word |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock, idles low |
| flash_dout | output | 4 | Values driven onto the four data lanes |
| flash_oe | output | 4 | Per-lane output enable |
| flash_din | input | 4 | Values read back from the four data lanes |

## Verification
Each result is due at a fixed offset from a stimulus:
- the first serial rise comes `CS_SETUP + CLK_DIV/2` cycles after chip select falls;
- each later rise comes `CLK_DIV` cycles after the one before;
- chip select rises `CS_HOLD` cycles after the final serial fall;
- a word's strobe arrives together with the serial rise that captures its eighth nibble.

The bench's flash model timestamps every chip-select and serial-clock edge with a cycle counter that advances on the falling system clock edge, and compares the exact differences to these offsets. Words are read at falling edges, so the strobe is seen in its one valid cycle and the received count must match the burst length exactly.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
  localparam int FLASH_AW = 24;
  localparam logic [7:0] RD_OPCODE = 8'hEB;
  // serial-cycle boundaries of the fixed phase sequence
  localparam int CMD_END    = 8;
  localparam int ADDR_END   = 14;
  localparam int MODE_END   = 16;
  localparam int DATA_BEGIN = 20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } seq_state_t;

  typedef struct packed {
    logic [3:0] dout;
    logic [3:0] oe;
  } lane_t;
endpackage

// File: rtl/qspi_sck_gen.sv
module qspi_sck_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;

  assign rise_tick = run && (cnt == CW'(HALF - 1));
  assign fall_tick = run && (cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (fall_tick) begin
      cnt <= '0;
      sck <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise_tick) sck <= 1'b1;
    end
  end
endmodule

// File: rtl/qspi_lane_drive.sv
module qspi_lane_drive
  import qspi_rd_pkg::*;
#(
  parameter int         K_W      = 8,
  parameter logic [3:0] MODE_LOW = 4'h0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                clear,
  input  logic [K_W-1:0]      idx,
  input  logic [FLASH_AW-1:0] addr,
  output logic [3:0]          dout,
  output logic [3:0]          oe
);
  function automatic lane_t drive_at(input logic [K_W-1:0] k,
                                     input logic [FLASH_AW-1:0] a);
    lane_t r;
    int    i;
    i      = int'(k);
    r.dout = 4'h0;
    r.oe   = 4'h0;
    if (i < CMD_END) begin
      r.dout = {3'b000, RD_OPCODE[3'(CMD_END - 1 - i)]};
      r.oe   = 4'b0001;
    end else if (i < ADDR_END) begin
      r.dout = 4'(a >> (4 * (ADDR_END - 1 - i)));
      r.oe   = 4'hF;
    end else if (i < MODE_END) begin
      r.dout = (i == ADDR_END) ? 4'hF : MODE_LOW;
      r.oe   = 4'hF;
    end
    return r;
  endfunction

  lane_t nxt;
  assign nxt = drive_at(idx, addr);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      dout <= 4'h0;
      oe   <= 4'h0;
    end else if (load) begin
      dout <= nxt.dout;
      oe   <= nxt.oe;
    end
  end
endmodule

// File: rtl/qspi_word_pack.sv
module qspi_word_pack (
  input  logic        clk,
  input  logic        rst,
  input  logic        sample,
  input  logic [2:0]  nib_idx,
  input  logic [3:0]  din,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  logic [31:0] acc;
  logic [31:0] nxt;
  logic [4:0]  pos;

  // byte number in [2:1], high nibble of a byte arrives first
  assign pos = {nib_idx[2:1], ~nib_idx[0], 2'b00};

  always_comb begin
    nxt = acc;
    nxt[pos +: 4] = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (sample) begin
        acc <= nxt;
        if (nib_idx == 3'd7) begin
          rd_data  <= nxt;
          rd_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader
  import qspi_rd_pkg::*;
#(
  parameter int         CLK_DIV  = 4,
  parameter int         LEN_W    = 4,
  parameter int         CS_SETUP = 3,
  parameter int         CS_HOLD  = 3,
  parameter int         CS_GAP   = 2,
  parameter logic [3:0] MODE_LOW = 4'h0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [FLASH_AW-1:0] req_addr,
  input  logic [LEN_W-1:0]    req_len,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  output logic                flash_cs_n,
  output logic                flash_sck,
  output logic [3:0]          flash_dout,
  output logic [3:0]          flash_oe,
  input  logic [3:0]          flash_din
);
  localparam int MAX_K = DATA_BEGIN + 8 * (2 ** LEN_W);
  localparam int K_W   = $clog2(MAX_K + 1);

  seq_state_t          state;
  logic [7:0]          tmr;
  logic [K_W-1:0]      k;
  logic [K_W-1:0]      last_k;
  logic [FLASH_AW-1:0] addr_q;
  logic                ready_q;
  logic                cs_n_q;

  logic           run, rise_tick, fall_tick;
  logic           accept, step, finish;
  logic [K_W-1:0] lane_idx;

  assign accept   = req_valid && ready_q;
  assign run      = (state == ST_SHIFT);
  assign step     = run && fall_tick && (k != last_k);
  assign finish   = run && fall_tick && (k == last_k);
  assign lane_idx = accept ? '0 : (k + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      k       <= '0;
      last_k  <= '0;
      addr_q  <= '0;
      ready_q <= 1'b1;
      cs_n_q  <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_SETUP;
          ready_q <= 1'b0;
          cs_n_q  <= 1'b0;
          tmr     <= 8'(CS_SETUP - 1);
          k       <= '0;
          addr_q  <= req_addr;
          last_k  <= K_W'(DATA_BEGIN + 7) + (K_W'(req_len) << 3);
        end
        ST_SETUP: begin
          if (tmr == 8'd0) state <= ST_SHIFT;
          else             tmr   <= tmr - 1'b1;
        end
        ST_SHIFT: begin
          if (finish) begin
            state <= ST_HOLD;
            tmr   <= 8'(CS_HOLD - 1);
          end else if (step) begin
            k <= k + 1'b1;
          end
        end
        ST_HOLD: begin
          if (tmr == 8'd0) begin
            cs_n_q <= 1'b1;
            state  <= ST_GAP;
            tmr    <= 8'(CS_GAP - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_GAP: begin
          if (tmr == 8'd0) begin
            state   <= ST_IDLE;
            ready_q <= 1'b1;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = ready_q;
  assign flash_cs_n = cs_n_q;

  qspi_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
    .clk(clk), .rst(rst), .run(run),
    .sck(flash_sck), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  qspi_lane_drive #(.K_W(K_W), .MODE_LOW(MODE_LOW)) u_lane (
    .clk(clk), .rst(rst), .load(accept || step), .clear(finish),
    .idx(lane_idx), .addr(addr_q), .dout(flash_dout), .oe(flash_oe)
  );

  qspi_word_pack u_pack (
    .clk(clk), .rst(rst),
    .sample(rise_tick && (k >= K_W'(DATA_BEGIN))),
    .nib_idx(3'(k - K_W'(DATA_BEGIN))),
    .din(flash_din),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/qspi_quad_reader_chk.sv
module qspi_quad_reader_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       flash_cs_n,
  input logic       flash_sck,
  input logic [3:0] flash_oe
);
  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (rst)
    flash_cs_n |-> !flash_sck);

  assert_lanes_off_R9: assert property (@(posedge clk) disable iff (rst)
    flash_cs_n |-> (flash_oe == 4'b0000));

  assert_oe_shape_R2: assert property (@(posedge clk) disable iff (rst)
    (flash_oe == 4'b0000) || (flash_oe == 4'b0001) || (flash_oe == 4'b1111));

  assert_word_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (!flash_cs_n && $rose(flash_sck)));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
    !flash_cs_n |-> !req_ready);

  assert_cs_after_handshake_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_cs_n) |-> $past(req_valid && req_ready));
endmodule

bind qspi_quad_reader qspi_quad_reader_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .flash_cs_n(flash_cs_n), .flash_sck(flash_sck),
  .flash_oe(flash_oe)
);

// File: tb/tb_qspi_quad_reader.sv
module tb_qspi_quad_reader;
  localparam int CLK_DIV  = 4;
  localparam int LEN_W    = 4;
  localparam int CS_SETUP = 3;
  localparam int CS_HOLD  = 3;
  localparam int CS_GAP   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        flash_cs_n, flash_sck;
  logic [3:0]  flash_dout, flash_oe;
  logic [3:0]  fl_drive = 4'h0;

  always #10 clk = ~clk;

  qspi_quad_reader #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .CS_SETUP(CS_SETUP),
                     .CS_HOLD(CS_HOLD), .CS_GAP(CS_GAP), .MODE_LOW(4'h0)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data),
    .flash_cs_n(flash_cs_n), .flash_sck(flash_sck), .flash_dout(flash_dout),
    .flash_oe(flash_oe), .flash_din(fl_drive)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
  endfunction

  // cycle counter advances on the falling edge so edge stamps are race free
  int cyc = 0;
  always @(negedge clk) cyc++;

  // flash model
  int rises, cs_falls = 0, period_bad, cmd_oe_bad, ad_oe_bad, rel_oe_bad;
  int csf_t, first_rise_t, prev_rise_t, last_fall_t, csr_t = 0, gap_last = 0;
  logic [7:0]  op, md;
  logic [23:0] fa;
  int d;
  logic [7:0] b;

  always @(negedge flash_cs_n) begin
    rises = 0; csf_t = cyc; cs_falls++; gap_last = cyc - csr_t;
  end
  always @(posedge flash_cs_n) csr_t = cyc;

  always @(posedge flash_sck) if (!flash_cs_n) begin
    if (rises == 0) first_rise_t = cyc;
    else if (cyc - prev_rise_t != CLK_DIV) period_bad++;
    prev_rise_t = cyc;
    if (rises < 8) begin
      op = {op[6:0], flash_dout[0]};
      if (flash_oe != 4'b0001) cmd_oe_bad++;
    end else if (rises < 14) begin
      fa = {fa[19:0], flash_dout};
      if (flash_oe != 4'hF) ad_oe_bad++;
    end else if (rises < 16) begin
      md = {md[3:0], flash_dout};
      if (flash_oe != 4'hF) ad_oe_bad++;
    end else if (flash_oe != 4'h0) rel_oe_bad++;
    rises++;
  end

  always @(negedge flash_sck) if (flash_cs_n === 1'b0) begin
    last_fall_t = cyc;
    if (rises >= 20) begin
      d = rises - 20;
      b = mem_byte(fa + 24'(d / 2));
      fl_drive = (d % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  // received words and ready monitor
  logic [31:0] rx [0:63];
  int rx_n = 0;
  int ready_bad = 0;
  always @(negedge clk) if (!rst) begin
    if (rd_valid) begin
      if (rx_n < 64) rx[rx_n] = rd_data;
      rx_n++;
    end
    if (!flash_cs_n && req_ready) ready_bad++;
  end

  function automatic logic [31:0] exp_word(input logic [23:0] a, input int w);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = mem_byte(a + 24'(4 * w + i));
    return r;
  endfunction

  task automatic clear_model();
    period_bad = 0; cmd_oe_bad = 0; ad_oe_bad = 0; rel_oe_bad = 0; rx_n = 0;
  endtask

  task automatic issue(input logic [23:0] a, input int len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_txn(input logic [23:0] a, input int len, input int base, input int c0);
    int n;
    n = len + 1;
    chk(op == 8'hEB, "R2 opcode", op, 8'hEB);
    chk(cmd_oe_bad == 0, "R2 command lane enables", cmd_oe_bad, 0);
    chk(fa == a, "R3 address", fa, a);
    chk(ad_oe_bad == 0, "R3 address/mode lane enables", ad_oe_bad, 0);
    chk(md[7:4] == 4'hF, "R4 mode upper nibble", md, 8'hF0);
    chk(rel_oe_bad == 0, "R5 lanes released", rel_oe_bad, 0);
    chk(rises == 20 + 8 * n, "R5 serial cycle count", rises, 20 + 8 * n);
    chk(cs_falls - c0 == 1, "R7 single chip select", cs_falls - c0, 1);
    chk(first_rise_t - csf_t == CS_SETUP + CLK_DIV / 2, "R8 setup",
        first_rise_t - csf_t, CS_SETUP + CLK_DIV / 2);
    chk(csr_t - last_fall_t == CS_HOLD, "R9 hold", csr_t - last_fall_t, CS_HOLD);
    chk(period_bad == 0, "R11 serial clock period", period_bad, 0);
    for (int w = 0; w < n; w++)
      chk(rx[base + w] == exp_word(a, w), "R6 word data", rx[base + w], exp_word(a, w));
  endtask

  task automatic do_read(input logic [23:0] a, input int len);
    int c0;
    clear_model();
    c0 = cs_falls;
    issue(a, len);
    @(posedge flash_cs_n);
    repeat (4) @(negedge clk);
    chk(rx_n == len + 1, "R7 word count", rx_n, len + 1);
    check_txn(a, len, 0, c0);
    chk(flash_sck == 1'b0 && flash_oe == 4'h0, "R9 idle lines", {flash_sck, flash_oe}, 0);
  endtask

  task automatic test_reset();
    chk(flash_cs_n == 1'b1, "R1 cs_n", flash_cs_n, 1);
    chk(flash_sck == 1'b0, "R1 sck", flash_sck, 0);
    chk(flash_oe == 4'h0, "R1 oe", flash_oe, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
  endtask

  task automatic test_back_to_back();
    int c0;
    clear_model();
    c0 = cs_falls;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = 24'h000040; req_len = LEN_W'(1); req_valid = 1'b1;
    while (cs_falls != c0 + 2) @(negedge clk);
    req_valid = 1'b0;
    chk(gap_last >= CS_GAP, "R10 chip select high gap", gap_last, CS_GAP);
    @(posedge flash_cs_n);
    repeat (4) @(negedge clk);
    chk(rx_n == 4, "R7 two bursts word count", rx_n, 4);
    chk(ready_bad == 0, "R10 ready low while busy", ready_bad, 0);
    for (int w = 0; w < 2; w++)
      chk(rx[2 + w] == exp_word(24'h000040, w), "R6 second burst data",
          rx[2 + w], exp_word(24'h000040, w));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    do_read(24'h000123, 0);
    do_read(24'h0004FE, 3);
    do_read(24'hFFFFFA, 2);   // R3 wrap past top of the 24-bit space
    do_read(24'h7FFFF0, 15);
    test_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule